// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a parameterised set of peripheral sources, latches each one into a flag bit, and reports a single source number to the processor. Each source has a flag bit, an enable bit, a 5-bit priority code and a 32-bit vector offset word. All of these are reached over a simple 32-bit register bus. The flag, enable, priority and control registers each have alias addresses that write, clear, set or invert only the bits written as 1.

Three kinds of request are supported. A plain edge source raises its flag on a rising request. A persistent (level) source keeps forcing its flag while its request stays high, so software must remove the cause before a clear can take effect. Eight designated external sources raise their flag on either the rising or the falling edge, as chosen by a control bit. Every cycle, an arbiter picks the highest non-zero priority code among the flagged and enabled sources; on a tie, the lowest source number wins. The result is registered onto `irq_pending` and `irq_id`, and it can also be read through the status register.

Top module: `prio_intc`

## Requirements
- R1: After reset, every flag, enable, priority, control and vector word reads 0, and `irq_pending` and `irq_id` are 0.
- R2: Source n has its flag at byte address 0x040 + 0x10*(n/32) and its enable at 0x0C0 + 0x10*(n/32), both at bit n%32. Addresses outside the mapped registers read 0.
- R3: Address bits [3:2] of a register access choose the operation: 0 replaces the register, 1 clears the bits written as 1, 2 sets them, and 3 inverts them. Bits written as 0 keep their value, and all four aliases read the register.
- R4: The priority code of source n is in register 0x140 + 0x10*(n/4), bits (n%4)*8 up to +4. The code is major priority (3 bits) shifted left by 2, ORed with the sub-priority (2 bits). The top 3 bits of each byte lane always read 0.
- R5: The selected source is the one with the highest code among sources whose flag and enable are both 1. Ties go to the lowest number. The choice appears on `irq_id` and `irq_pending` one clock after the flag, enable and priority state that produced it.
- R6: A code of 0 makes a source ineligible. When no source is eligible, `irq_pending` is 0 and the id reads 0.
- R7: For an edge source (every source that is neither level nor external), the flag sets on a 0-to-1 request change only. A request held high does not set the flag again after a clear.
- R8: A level source (default sources 0 to 3) forces its flag to 1 on every clock while its request is high. A clear in that cycle leaves the flag at 1. Once the request is low, a clear works.
- R9: Control register bits 0 to 7 (address 0x000) select the active edge of external sources 16 to 23, where source 16+i uses bit i. A value of 1 selects rising and 0 selects falling; the other edge sets nothing. Control bits above 7 read 0.
- R10: Source n has a read/write 32-bit vector word at 0x540 + 4*n.
- R11: The status register at 0x020 returns the registered selected id in its low 8 bits. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| src_req | input | NUM_SRC | Request line of each source |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pending | output | 1 | An eligible source exists (registered) |
| irq_id | output | log2(NUM_SRC) | Number of the selected source (registered) |

## Verification
The assertions assume that `src_req` is synchronous to `clk` and that no external source is also marked level. They also assume at most one register write per cycle, at a word-aligned address. The stimulus meets these assumptions: it changes requests and bus signals only on the falling clock edge, pulses `bus_wr` for exactly one cycle, and uses aligned addresses only. It exercises edge, level and external sources separately, so each kind of set event can be tied to its own flag bit.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } alias_op_e;

  localparam int A_CTRL = 'h000;
  localparam int A_STAT = 'h020;
  localparam int A_FLAG = 'h040;
  localparam int A_EN   = 'h0C0;
  localparam int A_PRI  = 'h140;
  localparam int A_VEC  = 'h540;

  localparam int PRI_W  = 5;
  localparam int LANE_W = 8;
  localparam int STAT_W = 8;

  function automatic logic [31:0] alias_apply(alias_op_e op, logic [31:0] cur, logic [31:0] w);
    logic [31:0] r;
    case (op)
      OP_WRITE: r = w;
      OP_CLR:   r = cur & ~w;
      OP_SET:   r = cur | w;
      default:  r = cur ^ w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/icu_areg.sv
module icu_areg
  import icu_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  alias_op_e   op,
  input  logic [31:0] wdata,
  input  logic [31:0] hw_set,
  output logic [31:0] q
);

  logic [31:0] d;
  logic        ce;

  // hardware set events are ORed in after the bus operation, so they win
  always_comb begin
    ce = sel | (|(hw_set & IMPL_MASK));
    d  = q;
    if (sel) d = alias_apply(op, q, wdata);
    d = (d | hw_set) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & IMPL_MASK)) |=> ((q & $past(hw_set & IMPL_MASK)) == $past(hw_set & IMPL_MASK)));

  assert_clear_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_CLR && hw_set == '0) |=> ((q & $past(wdata & IMPL_MASK)) == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && hw_set == '0) |=> $stable(q));

endmodule

// File: rtl/icu_edge.sv
module icu_edge #(
  parameter int           N          = 64,
  parameter logic [255:0] LEVEL_MASK = 256'hF,
  parameter int           EXT_BASE   = 16,
  parameter int           NUM_EXT    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req,
  input  logic [NUM_EXT-1:0] pol,
  output logic [N-1:0]       evt
);

  logic [N-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign evt[i] = req[i];
    end else if (i >= EXT_BASE && i < EXT_BASE + NUM_EXT) begin : g_ext
      assign evt[i] = pol[i-EXT_BASE] ? (req[i] & ~req_q[i]) : (~req[i] & req_q[i]);
    end else begin : g_rise
      assign evt[i] = req[i] & ~req_q[i];
    end
  end

  assert_edge_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~LEVEL_MASK[N-1:0] & $past(evt)) == '0));

endmodule

// File: rtl/icu_arb.sv
module icu_arb
  import icu_pkg::*;
#(
  parameter int N    = 64,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]            act,
  input  logic [N-1:0][PRI_W-1:0] code,
  output logic                    found,
  output logic [ID_W-1:0]         id
);

  logic [PRI_W-1:0] best;

  // strict greater-than keeps the lowest index on a tie; code 0 never beats 0
  always_comb begin
    best  = '0;
    id    = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && code[i] > best) begin
        best  = code[i];
        id    = ID_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import icu_pkg::*;
#(
  parameter int           NUM_SRC    = 64,
  parameter int           NUM_EXT    = 8,
  parameter int           EXT_BASE   = 16,
  parameter logic [255:0] LEVEL_MASK = 256'hF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_req,
  input  logic [11:0]                bus_addr,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       irq_pending,
  output logic [$clog2(NUM_SRC)-1:0] irq_id
);

  localparam int          ID_W      = $clog2(NUM_SRC);
  localparam int          NUM_WREG  = NUM_SRC / 32;
  localparam int          NUM_PREG  = NUM_SRC / 4;
  localparam logic [31:0] CTRL_MASK = (32'd1 << NUM_EXT) - 32'd1;
  localparam logic [31:0] PRI_MASK  = 32'h1F1F_1F1F;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  alias_op_e op;
  int        a, flag_idx, en_idx, pri_idx, vec_idx;
  logic      ctrl_hit, stat_hit, flag_hit, en_hit, pri_hit, vec_hit;

  always_comb begin
    op       = alias_op_e'(bus_addr[3:2]);
    a        = int'(bus_addr);
    ctrl_hit = (a >= A_CTRL) && (a < A_CTRL + 16);
    stat_hit = (a >= A_STAT) && (a < A_STAT + 16);
    flag_hit = (a >= A_FLAG) && (a < A_FLAG + 16 * NUM_WREG);
    en_hit   = (a >= A_EN)   && (a < A_EN   + 16 * NUM_WREG);
    pri_hit  = (a >= A_PRI)  && (a < A_PRI  + 16 * NUM_PREG);
    vec_hit  = (a >= A_VEC)  && (a < A_VEC  + 4 * NUM_SRC);
    flag_idx = (a - A_FLAG) / 16;
    en_idx   = (a - A_EN) / 16;
    pri_idx  = (a - A_PRI) / 16;
    vec_idx  = (a - A_VEC) / 4;
  end

  // control register: external edge polarity
  logic [31:0] ctrl_q;

  icu_areg #(.IMPL_MASK(CTRL_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .sel(bus_wr && ctrl_hit), .op(op),
    .wdata(bus_wdata), .hw_set(32'd0), .q(ctrl_q)
  );

  // request event detection
  logic [NUM_SRC-1:0] evt;

  icu_edge #(
    .N(NUM_SRC), .LEVEL_MASK(LEVEL_MASK), .EXT_BASE(EXT_BASE), .NUM_EXT(NUM_EXT)
  ) u_edge (
    .clk(clk), .rst_n(rst_int_n), .req(src_req), .pol(ctrl_q[NUM_EXT-1:0]), .evt(evt)
  );

  // flag and enable words
  logic [31:0]        flag_w [NUM_WREG];
  logic [31:0]        en_w   [NUM_WREG];
  logic [NUM_SRC-1:0] flag_vec, en_vec, act_vec;

  for (genvar k = 0; k < NUM_WREG; k++) begin : g_word
    icu_areg u_flag (
      .clk(clk), .rst_n(rst_int_n), .sel(bus_wr && flag_hit && flag_idx == k), .op(op),
      .wdata(bus_wdata), .hw_set(evt[k*32 +: 32]), .q(flag_w[k])
    );
    icu_areg u_en (
      .clk(clk), .rst_n(rst_int_n), .sel(bus_wr && en_hit && en_idx == k), .op(op),
      .wdata(bus_wdata), .hw_set(32'd0), .q(en_w[k])
    );
    assign flag_vec[k*32 +: 32] = flag_w[k];
    assign en_vec[k*32 +: 32]   = en_w[k];
  end

  assign act_vec = flag_vec & en_vec;

  // priority words, four byte lanes each
  logic [31:0]                   pri_w [NUM_PREG];
  logic [NUM_SRC-1:0][PRI_W-1:0] code;

  for (genvar k = 0; k < NUM_PREG; k++) begin : g_pri
    icu_areg #(.IMPL_MASK(PRI_MASK)) u_pri (
      .clk(clk), .rst_n(rst_int_n), .sel(bus_wr && pri_hit && pri_idx == k), .op(op),
      .wdata(bus_wdata), .hw_set(32'd0), .q(pri_w[k])
    );
    for (genvar j = 0; j < 4; j++) begin : g_lane
      assign code[k*4+j] = pri_w[k][j*LANE_W +: PRI_W];
    end
  end

  // vector offset words
  logic [31:0] vec_q [NUM_SRC];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NUM_SRC; i++) vec_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (bus_wr && vec_hit && vec_idx == i) vec_q[i] <= bus_wdata;
    end
  end

  // arbitration and registered status
  logic            win_found;
  logic [ID_W-1:0] win_id;
  logic            pend_d;
  logic [ID_W-1:0] id_d;

  icu_arb #(.N(NUM_SRC), .ID_W(ID_W)) u_arb (
    .act(act_vec), .code(code), .found(win_found), .id(win_id)
  );

  always_comb begin
    pend_d = win_found;
    id_d   = win_found ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_pending <= 1'b0;
      irq_id      <= '0;
    end else begin
      irq_pending <= pend_d;
      irq_id      <= id_d;
    end
  end

  // read mux
  logic [STAT_W-1:0] stat_id;

  always_comb begin
    stat_id             = '0;
    stat_id[ID_W-1:0]   = irq_id;
    bus_rdata           = '0;
    if (ctrl_hit) bus_rdata = ctrl_q;
    if (stat_hit) bus_rdata = {{(32-STAT_W){1'b0}}, stat_id};
    for (int k = 0; k < NUM_WREG; k++) begin
      if (flag_hit && flag_idx == k) bus_rdata = flag_w[k];
      if (en_hit && en_idx == k)     bus_rdata = en_w[k];
    end
    for (int k = 0; k < NUM_PREG; k++)
      if (pri_hit && pri_idx == k) bus_rdata = pri_w[k];
    for (int i = 0; i < NUM_SRC; i++)
      if (vec_hit && vec_idx == i) bus_rdata = vec_q[i];
  end

  // a reported source was eligible on the previous clock
  assert_pending_source_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_pending |-> ((($past(act_vec)) & ({{(NUM_SRC-1){1'b0}}, 1'b1} << irq_id)) != '0));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(|act_vec) |-> (!irq_pending && irq_id == '0));

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

  localparam int CLK_P = 10;
  localparam int N     = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_req;
  logic [11:0]   bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_pending;
  logic [5:0]    irq_id;

  always #(CLK_P/2) clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pending(irq_pending), .irq_id(irq_id)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_flag [N];
  bit          m_en   [N];
  bit          m_rq   [N];
  int          m_pri  [N];
  bit [31:0]   m_vec  [N];
  int          m_ctrl;
  bit          m_pend;
  int          m_id;
  int          rcnt;

  function automatic bit [31:0] apply_op(int op, bit [31:0] o, bit [31:0] w);
    case (op)
      0: return w;
      1: return o & ~w;
      2: return o | w;
      default: return o ^ w;
    endcase
  endfunction

  function automatic bit [31:0] mread(int a);
    bit [31:0] v = 0;
    int base = a & ~12;
    if ((a >> 4) == 0) return m_ctrl;
    if ((a >> 4) == 2) return m_id;
    for (int n = 0; n < N; n++) begin
      if (base == 'h40 + 16*(n/32) && m_flag[n]) v[n%32] = 1'b1;
      if (base == 'hC0 + 16*(n/32) && m_en[n])   v[n%32] = 1'b1;
      if (base == 'h140 + 16*(n/4)) v = v | (m_pri[n] << ((n%4)*8));
    end
    if (a >= 'h540 && a < 'h540 + 4*N) v = m_vec[(a - 'h540)/4];
    return v;
  endfunction

  function automatic string tag_of(int a);
    if (a < 'h20) return "R9";
    if (a < 'h40) return "R11";
    if (a < 'h140) return "R2";
    if (a < 'h540) return "R4";
    return "R10";
  endfunction

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < N; n++) begin
      m_flag[n] = 0; m_en[n] = 0; m_rq[n] = 0; m_pri[n] = 0; m_vec[n] = 0;
    end
    m_ctrl = 0; m_pend = 0; m_id = 0;
  endtask

  task automatic model_step();
    bit ev [N];
    int best = 0;
    int op = int'(bus_addr[3:2]);
    int a = int'(bus_addr);
    int base = a & ~12;
    bit np = 0;
    int nid = 0;
    for (int n = 0; n < N; n++)
      if (m_flag[n] && m_en[n] && m_pri[n] > best) begin best = m_pri[n]; np = 1; nid = n; end
    for (int n = 0; n < N; n++) begin
      if (n < 4) ev[n] = src_req[n];
      else if (n >= 16 && n < 24)
        ev[n] = m_ctrl[n-16] ? (src_req[n] && !m_rq[n]) : (!src_req[n] && m_rq[n]);
      else ev[n] = src_req[n] && !m_rq[n];
      m_rq[n] = src_req[n];
    end
    if (bus_wr) begin
      if ((a >> 4) == 0) m_ctrl = apply_op(op, m_ctrl, bus_wdata) & 'hFF;
      for (int n = 0; n < N; n++) begin
        if (base == 'h40 + 16*(n/32))
          m_flag[n] = apply_op(op, m_flag[n], bus_wdata[n%32]) & 1;
        if (base == 'hC0 + 16*(n/32))
          m_en[n] = apply_op(op, m_en[n], bus_wdata[n%32]) & 1;
        if (base == 'h140 + 16*(n/4))
          m_pri[n] = apply_op(op, m_pri[n], (bus_wdata >> ((n%4)*8)) & 31) & 31;
        if (a == 'h540 + 4*n) m_vec[n] = bus_wdata;
      end
    end
    for (int n = 0; n < N; n++) if (ev[n]) m_flag[n] = 1;
    m_pend = np; m_id = nid;
  endtask

  // reference model advanced and compared on every clock
  always @(posedge clk) begin
    if (!rst_n) rcnt = 0;
    else if (rcnt < 3) rcnt++;
    if (!rst_n || rcnt < 3) model_reset();
    else model_step();
    #1;
    if (rst_n && !done) begin
      check("R5", irq_pending, m_pend, "irq_pending vs model");
      check("R5", irq_id, m_id, "irq_id vs model");
      check(tag_of(int'(bus_addr)), bus_rdata, mread(int'(bus_addr)), "bus_rdata vs model");
    end
  end

  task automatic wr(int a, bit [31:0] d);
    @(negedge clk); bus_addr = a[11:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic expect_rd(int a, bit [31:0] e, string tag);
    @(negedge clk); bus_addr = a[11:0];
    @(posedge clk); #2;
    check(tag, bus_rdata, e, $sformatf("read %h", a));
  endtask

  task automatic expect_irq(bit p, int id, string tag);
    @(posedge clk); #2;
    check(tag, irq_pending, p, "irq_pending");
    check(tag, irq_id, id, "irq_id");
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_req(int n, bit v);
    @(negedge clk); src_req[n] = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; src_req = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    expect_irq(0, 0, "R1");
    expect_rd('h040, 0, "R1");
    expect_rd('h0C0, 0, "R1");
    expect_rd('h140, 0, "R1");
    expect_rd('h540, 0, "R10");

    // R3 alias operations on enable word 0
    wr('h0C0, 32'hFFFF_FFFF);
    wr('h0C4, 32'h0000_FF00);
    expect_rd('h0C0, 32'hFFFF_00FF, "R3");
    wr('h0C8, 32'h0000_0100);
    expect_rd('h0C0, 32'hFFFF_01FF, "R3");
    wr('h0CC, 32'h0000_000F);
    expect_rd('h0C4, 32'hFFFF_01F0, "R3");
    wr('h0C0, 32'hFFFF_FFFF);
    wr('h0D0, 32'hFFFF_FFFF);
    expect_rd('h0D0, 32'hFFFF_FFFF, "R2");
    expect_rd('h060, 0, "R2");

    // R4 lane masking
    wr('h140, 32'hFFFF_FFFF);
    expect_rd('h140, 32'h1F1F_1F1F, "R4");
    wr('h140, 0);

    // R5 tie and priority order, R11 status
    wr('h150, 32'h0000_0800);
    wr('h160, 32'h0000_0800);
    wr('h048, 32'h0000_0220);
    idle(2);
    expect_irq(1, 5, "R5");
    expect_rd('h020, 5, "R11");
    wr('h160, 32'h0000_0900);
    idle(2);
    expect_irq(1, 9, "R5");
    wr('h020, 32'h0000_00FF);
    expect_rd('h020, 9, "R11");

    // R6 code zero ineligible, nothing pending
    wr('h058, 32'h0004_0000);
    wr('h044, 32'hFFFF_FFFF);
    idle(2);
    expect_irq(0, 0, "R6");
    expect_rd('h020, 0, "R6");
    expect_rd('h050, 32'h0004_0000, "R2");

    // R5 several competitors and enable masking
    wr('h1C0, 32'h0000_1F00);
    wr('h1E0, 32'h0000_001F);
    wr('h058, 32'h0000_0102);
    wr('h048, 32'h0000_0020);
    idle(2);
    expect_irq(1, 33, "R5");
    wr('h0D4, 32'h0000_0002);
    idle(2);
    expect_irq(1, 40, "R5");
    wr('h054, 32'h0000_0100);
    idle(2);
    expect_irq(1, 5, "R5");
    wr('h044, 32'hFFFF_FFFF);
    wr('h054, 32'hFFFF_FFFF);
    idle(2);
    expect_irq(0, 0, "R6");

    // R7 edge source 30
    set_req(30, 1);
    idle(2);
    expect_rd('h040, 32'h4000_0000, "R7");
    wr('h044, 32'h4000_0000);
    expect_rd('h040, 0, "R7");
    set_req(30, 0);
    idle(1);
    expect_rd('h040, 0, "R7");

    // R8 level source 2
    set_req(2, 1);
    idle(2);
    wr('h044, 32'h0000_0004);
    expect_rd('h040, 32'h0000_0004, "R8");
    set_req(2, 0);
    wr('h044, 32'h0000_0004);
    expect_rd('h040, 0, "R8");

    // R9 external source 17 polarity
    wr('h000, 32'h0000_01FF);
    expect_rd('h000, 32'h0000_00FF, "R9");
    wr('h000, 0);
    set_req(17, 1);
    idle(2);
    expect_rd('h040, 0, "R9");
    set_req(17, 0);
    idle(2);
    expect_rd('h040, 32'h0002_0000, "R9");
    wr('h044, 32'h0002_0000);
    wr('h008, 32'h0000_0002);
    expect_rd('h000, 32'h0000_0002, "R9");
    set_req(17, 1);
    idle(2);
    expect_rd('h040, 32'h0002_0000, "R9");
    wr('h044, 32'h0002_0000);
    set_req(17, 0);
    idle(2);
    expect_rd('h040, 0, "R9");

    // R10 vector words
    wr('h540 + 4*63, 32'hDEAD_BEEF);
    wr('h544, 32'h1234_5678);
    expect_rd('h540 + 4*63, 32'hDEAD_BEEF, "R10");
    expect_rd('h544, 32'h1234_5678, "R10");
    expect_rd('h548, 0, "R10");

    idle(3);
    finish_run();
  end

endmodule